// File: doc/BRIEF.md
# Page-Fixed Hardware Stack Unit

This block owns the 8-bit stack pointer of a small 8-bit processor whose stack is confined to one fixed 256-byte memory page (page 0x01, addresses 0x0100 to 0x01FF). The surrounding core hands it one command at a time. The command can push a byte, pull a byte into the accumulator or into the status register, push a 16-bit return address, pull a 16-bit return address, load the pointer from X, or copy the pointer out to X. The unit drives a byte-wide memory port with a 16-bit address, write data and a write enable. It reads memory combinationally, so read data for the presented address is valid in the same cycle. It returns pulled data and any N/Z flag update on a one-cycle result strobe.

The stack grows downward. The pointer always names the next free byte. A push writes at page plus pointer and then decrements the pointer. A pull first increments the pointer and then reads at page plus the new pointer. All pointer arithmetic wraps modulo 256, so the address never leaves the page. The pointer can only be reached through the two transfers with X.

The control is a small state machine. `ST_IDLE` accepts a command. A byte push moves to `ST_PUSH_BYTE` and a byte pull moves to `ST_PULL_BYTE`. A word push goes `ST_PUSH_HI` to `ST_PUSH_LO`, and a word pull goes `ST_PULL_LO` to `ST_PULL_HI`. Each of these states performs one memory access and the last one returns to `ST_IDLE`. The pointer transfers complete in `ST_IDLE` without a memory access.

Top module: `stack_unit`

## Requirements
- R1: After reset the pointer is 0xFF, `busy`, `mem_we` and `res_valid` are low, and a pointer read returns 0xFF.
- R2: Opcodes on `cmd_op` are 0 none, 1 push byte, 2 pull to accumulator, 3 pull to status, 4 push word, 5 pull word, 6 load pointer from `cmd_byte`, 7 read pointer. A command is taken only while `busy` is low.
- R3: A byte push writes `cmd_byte` to address 0x0100 plus the pointer in the cycle after acceptance, and then the pointer is one lower.
- R4: A byte pull increments the pointer and reads address 0x0100 plus the new pointer in the cycle after acceptance. One cycle later `res_valid` pulses with the byte in `res_data[7:0]` and zero in the upper byte.
- R5: Pull to accumulator raises `nz_we` with `flag_n` equal to bit 7 and `flag_z` set when the byte is zero. Pull to status raises `psr_we` and leaves `nz_we` low.
- R6: A word push writes `cmd_word[15:8]` on the first access and `cmd_word[7:0]` on the second, each at the then-current pointer, and lowers the pointer by two.
- R7: A word pull reads the low byte first and the high byte second, each after an increment. It returns `{high, low}` with no flag update.
- R8: Load pointer sets the pointer to `cmd_byte` with no result and no flag update. Read pointer returns the pointer on the next cycle with `nz_we` and N/Z computed from it.
- R9: Pointer arithmetic wraps modulo 256 and the address high byte is always 0x01.
- R10: A command presented while `busy` is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_byte | input | 8 | Byte to push or value for pointer load |
| cmd_word | input | 16 | Word to push |
| busy | output | 1 | Multi-cycle command in progress |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid for the current address |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Pulled byte, word or pointer value |
| nz_we | output | 1 | N/Z flags update strobe |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| psr_we | output | 1 | Whole status register update strobe |

## Verification
On every cycle the assertions check several rules. After a write the pointer is one below the written address, and after a pull access the pointer equals the address just read. Results appear only when the machine is idle. The two flag strobes never fire together, and a flag strobe never fires without a result. Some behaviour only the bench's scenarios can show: the exact order and addresses of the word accesses, that pulled data matches what earlier pushes stored, the wrap at both ends of the page, and that a command issued while busy leaves the pointer untouched. It shows these with a sweep over every pointer value and runs that push and pull past the page boundary.

// File: rtl/stack_pkg.sv
package stack_pkg;

    typedef enum logic [2:0] {
        OP_NOP       = 3'd0,
        OP_PUSH_BYTE = 3'd1,
        OP_PULL_ACC  = 3'd2,
        OP_PULL_PSR  = 3'd3,
        OP_PUSH_WORD = 3'd4,
        OP_PULL_WORD = 3'd5,
        OP_LOAD_SP   = 3'd6,
        OP_READ_SP   = 3'd7
    } stk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PUSH_BYTE = 3'd1,
        ST_PULL_BYTE = 3'd2,
        ST_PUSH_HI   = 3'd3,
        ST_PUSH_LO   = 3'd4,
        ST_PULL_LO   = 3'd5,
        ST_PULL_HI   = 3'd6
    } stk_state_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] SP_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] sp_up
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    assign sp_up = sp + ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_INIT;
        end else if (load) begin
            sp <= load_val;
        end else if (inc) begin
            sp <= sp_up;
        end else if (dec) begin
            sp <= sp - ONE;
        end
    end

    // R9
    ctrl_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({inc, dec, load}) <= 1);

endmodule

// File: rtl/stk_nz.sv
module stk_nz #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] value,
    output logic              neg,
    output logic              zero
);

    assign neg  = value[DATA_W-1];
    assign zero = (value == '0);

endmodule

// File: rtl/stack_unit.sv
module stack_unit
    import stack_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] PAGE    = 8'h01,
    parameter logic [DATA_W-1:0] SP_INIT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [DATA_W-1:0]     cmd_byte,
    input  logic [2*DATA_W-1:0]   cmd_word,
    output logic                  busy,
    output logic [2*DATA_W-1:0]   mem_addr,
    output logic                  mem_we,
    output logic [DATA_W-1:0]     mem_wdata,
    input  logic [DATA_W-1:0]     mem_rdata,
    output logic                  res_valid,
    output logic [2*DATA_W-1:0]   res_data,
    output logic                  nz_we,
    output logic                  flag_n,
    output logic                  flag_z,
    output logic                  psr_we
);

    localparam int ADDR_W = 2 * DATA_W;

    stk_op_e            op;
    stk_state_e         state_q, state_d;
    logic               take;
    logic [ADDR_W-1:0]  wd_q;
    logic               to_psr_q;
    logic [DATA_W-1:0]  lo_q;
    logic [DATA_W-1:0]  sp, sp_up;
    logic               p_inc, p_dec, p_load;
    logic [DATA_W-1:0]  nz_src;
    logic               nz_n, nz_z;
    logic               pull_acc;

    assign op   = stk_op_e'(cmd_op);
    assign take = cmd_valid && (state_q == ST_IDLE);

    stk_ptr #(.DATA_W(DATA_W), .SP_INIT(SP_INIT)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (p_inc),
        .dec      (p_dec),
        .load     (p_load),
        .load_val (cmd_byte),
        .sp       (sp),
        .sp_up    (sp_up)
    );

    assign nz_src = (state_q == ST_PULL_BYTE) ? mem_rdata : sp;

    stk_nz #(.DATA_W(DATA_W)) u_nz (
        .value (nz_src),
        .neg   (nz_n),
        .zero  (nz_z)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    unique case (op)
                        OP_PUSH_BYTE: state_d = ST_PUSH_BYTE;
                        OP_PULL_ACC,
                        OP_PULL_PSR:  state_d = ST_PULL_BYTE;
                        OP_PUSH_WORD: state_d = ST_PUSH_HI;
                        OP_PULL_WORD: state_d = ST_PULL_LO;
                        default:      state_d = ST_IDLE;
                    endcase
                end
            end
            ST_PUSH_BYTE: state_d = ST_IDLE;
            ST_PULL_BYTE: state_d = ST_IDLE;
            ST_PUSH_HI:   state_d = ST_PUSH_LO;
            ST_PUSH_LO:   state_d = ST_IDLE;
            ST_PULL_LO:   state_d = ST_PULL_HI;
            ST_PULL_HI:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // per-state outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = wd_q[DATA_W-1:0];
        mem_addr  = {PAGE, sp};
        p_inc     = 1'b0;
        p_dec     = 1'b0;
        p_load    = take && (op == OP_LOAD_SP);
        unique case (state_q)
            ST_IDLE: ;
            ST_PUSH_BYTE, ST_PUSH_LO: begin
                mem_we = 1'b1;
                p_dec  = 1'b1;
            end
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_wdata = wd_q[ADDR_W-1:DATA_W];
                p_dec     = 1'b1;
            end
            ST_PULL_BYTE, ST_PULL_LO, ST_PULL_HI: begin
                mem_addr = {PAGE, sp_up};
                p_inc    = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy     = (state_q != ST_IDLE);
    assign pull_acc = !to_psr_q;

    // command capture and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q      <= '0;
            to_psr_q  <= 1'b0;
            lo_q      <= '0;
            res_valid <= 1'b0;
            res_data  <= '0;
            nz_we     <= 1'b0;
            psr_we    <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            nz_we     <= 1'b0;
            psr_we    <= 1'b0;
            if (take) begin
                wd_q     <= (op == OP_PUSH_WORD) ? cmd_word : {{DATA_W{1'b0}}, cmd_byte};
                to_psr_q <= (op == OP_PULL_PSR);
                if (op == OP_READ_SP) begin
                    res_valid <= 1'b1;
                    res_data  <= {{DATA_W{1'b0}}, sp};
                    nz_we     <= 1'b1;
                    flag_n    <= nz_n;
                    flag_z    <= nz_z;
                end
            end
            unique case (state_q)
                ST_PULL_BYTE: begin
                    res_valid <= 1'b1;
                    res_data  <= {{DATA_W{1'b0}}, mem_rdata};
                    nz_we     <= pull_acc;
                    psr_we    <= to_psr_q;
                    flag_n    <= nz_n;
                    flag_z    <= nz_z;
                end
                ST_PULL_LO: lo_q <= mem_rdata;
                ST_PULL_HI: begin
                    res_valid <= 1'b1;
                    res_data  <= {mem_rdata, lo_q};
                end
                default: ;
            endcase
        end
    end

    // R3
    push_post_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(mem_addr[DATA_W-1:0]) - DATA_W'(1)));

    // R4
    pull_pre_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_we) |=> (sp == $past(mem_addr[DATA_W-1:0])));

    // R5
    one_flag_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nz_we, psr_we}));

    // R8
    flags_need_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_we || psr_we) |-> res_valid);

    // R10
    result_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);

endmodule

// File: tb/sim_stack_unit.sv
module sim_stack_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [7:0]  cmd_byte = 8'd0;
    logic [15:0] cmd_word = 16'd0;
    logic        busy, mem_we, res_valid, nz_we, flag_n, flag_z, psr_we;
    logic [15:0] mem_addr, res_data;
    logic [7:0]  mem_wdata, mem_rdata;

    logic [7:0] mem [256];
    logic [7:0] refmem [256];
    logic [7:0] ref_sp;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_word(cmd_word), .busy(busy),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .res_valid(res_valid), .res_data(res_data),
        .nz_we(nz_we), .flag_n(flag_n), .flag_z(flag_z), .psr_we(psr_we)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] b, input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_byte = b; cmd_word = w;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        issue(3'd1, b, 16'h0);
        chk(mem_we && mem_addr == {8'h01, ref_sp} && mem_wdata == b, "R3 push access",
            {mem_we, 7'd0, mem_addr, mem_wdata}, {8'h80, 8'h01, ref_sp, b});
        refmem[ref_sp] = b;
        ref_sp = ref_sp - 8'd1;
    endtask

    task automatic pull_byte(input bit to_psr);
        logic [7:0] e;
        issue(to_psr ? 3'd3 : 3'd2, 8'h0, 16'h0);
        ref_sp = ref_sp + 8'd1;
        chk(!mem_we && mem_addr == {8'h01, ref_sp}, "R4 pull address", {15'd0, mem_we, mem_addr}, {16'd0, 8'h01, ref_sp});
        e = refmem[ref_sp];
        @(negedge clk);
        chk(res_valid && res_data == {8'h00, e}, "R4 pull data", {15'd0, res_valid, res_data}, {16'h1, 8'h00, e});
        if (to_psr)
            chk(psr_we && !nz_we, "R5 status pull strobes", {30'd0, psr_we, nz_we}, 32'h2);
        else
            chk(nz_we && !psr_we && flag_n == e[7] && flag_z == (e == 8'h00), "R5 acc pull flags",
                {28'd0, nz_we, psr_we, flag_n, flag_z}, {28'd0, 2'b10, e[7], e == 8'h00});
    endtask

    task automatic push_word(input logic [15:0] w);
        issue(3'd4, 8'h0, w);
        chk(mem_we && mem_addr == {8'h01, ref_sp} && mem_wdata == w[15:8], "R6 word push high",
            {8'd0, mem_addr, mem_wdata}, {8'd0, 8'h01, ref_sp, w[15:8]});
        refmem[ref_sp] = w[15:8];
        ref_sp = ref_sp - 8'd1;
        @(negedge clk);
        chk(mem_we && mem_addr == {8'h01, ref_sp} && mem_wdata == w[7:0], "R6 word push low",
            {8'd0, mem_addr, mem_wdata}, {8'd0, 8'h01, ref_sp, w[7:0]});
        refmem[ref_sp] = w[7:0];
        ref_sp = ref_sp - 8'd1;
    endtask

    task automatic pull_word(input logic [15:0] expw);
        issue(3'd5, 8'h0, 16'h0);
        ref_sp = ref_sp + 8'd1;
        chk(!mem_we && mem_addr == {8'h01, ref_sp}, "R7 word pull first address", {16'd0, mem_addr}, {16'd0, 8'h01, ref_sp});
        @(negedge clk);
        ref_sp = ref_sp + 8'd1;
        chk(!mem_we && mem_addr == {8'h01, ref_sp}, "R7 word pull second address", {16'd0, mem_addr}, {16'd0, 8'h01, ref_sp});
        @(negedge clk);
        chk(res_valid && res_data == expw && !nz_we && !psr_we, "R7 word pull result",
            {13'd0, res_valid, nz_we, psr_we, res_data}, {16'h4, expw});
    endtask

    task automatic load_sp(input logic [7:0] v);
        issue(3'd6, v, 16'h0);
        chk(!res_valid && !nz_we && !busy, "R8 load no result", {29'd0, res_valid, nz_we, busy}, 32'd0);
        ref_sp = v;
    endtask

    task automatic read_sp(input string tag);
        issue(3'd7, 8'h0, 16'h0);
        chk(res_valid && nz_we && res_data == {8'h00, ref_sp} && flag_n == ref_sp[7] && flag_z == (ref_sp == 8'h00),
            tag, {12'd0, res_valid, nz_we, flag_n, flag_z, res_data},
            {12'd0, 2'b11, ref_sp[7], ref_sp == 8'h00, 8'h00, ref_sp});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; refmem[i] = 8'h00; end
        ref_sp = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !mem_we && !res_valid, "R1 reset outputs", {29'd0, busy, mem_we, res_valid}, 32'd0);
        read_sp("R1 reset pointer");

        // R8 R2 exhaustive pointer load and read
        for (int v = 0; v < 256; v++) begin
            load_sp(8'(v));
            read_sp("R8 pointer readback");
        end

        // R3 R4 R5 R9 push past the page bottom, then pull back
        load_sp(8'h40);
        for (int i = 0; i < 300; i++) push_byte(8'(i * 37 + 128));
        read_sp("R9 pointer after wrap pushes");
        for (int i = 0; i < 300; i++) pull_byte(i % 5 == 0);
        read_sp("R9 pointer after pulls");

        // R9 wrap at both ends
        load_sp(8'h00);
        push_byte(8'h5A);
        read_sp("R9 push at 00 leaves FF");
        load_sp(8'hFF);
        pull_byte(1'b0);
        read_sp("R9 pull at FF leaves 00");

        // R6 R7 word ops including one straddling the wrap
        for (int s = 0; s < 256; s += 51) begin
            logic [15:0] w;
            w = 16'(s * 1031 + 16'hA55A);
            load_sp(8'(s));
            push_word(w);
            read_sp("R6 pointer down by two");
            pull_word(w);
            read_sp("R7 pointer restored");
        end
        load_sp(8'h00);
        push_word(16'hBEEF);
        pull_word(16'hBEEF);

        // R10 command during busy has no effect
        load_sp(8'h80);
        issue(3'd4, 8'h0, 16'h1234);
        cmd_valid = 1'b1; cmd_op = 3'd6; cmd_byte = 8'h33;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        ref_sp = 8'h7E;
        @(negedge clk);
        read_sp("R10 load ignored while busy");

        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule